// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device side of a serial flash link, reduced to its read path. It watches a chip-select line and a serial clock and shifts in one opcode byte followed by a three-byte address. For the three read commands it knows, it then streams bytes out of an internal array. The address advances by one after each byte and rolls over at the top of the array. One command drives one output lane. The other two commands first take a dummy byte, and one of them drives two lanes at once. The second lane reuses the serial input wire, which the device drives during that phase.

All pins are sampled by a single system clock that runs much faster than the serial clock, and the block acts on the edges it detects. Each output has a separate data and enable bit, which a pad ring or bench resolves into a tri-state wire. The array is small and parameterized as 2^ADDR_W bytes. It is loaded through a backdoor write port before traffic starts.

The controller has six named states:
- IDLE: waits for select to fall.
- OPCODE: collects 8 bits. A known opcode goes to ADDR; any other goes to IGNORE.
- ADDR: collects 24 bits. Opcode 03h goes to DATA; the others go to DUMMY.
- DUMMY: counts 8 clocks, then goes to DATA.
- DATA: streams bytes until select is released.
- IGNORE: stays quiet until select is released.

A high select returns every state to IDLE.

Top module: `flash_rd_responder`

## Requirements
- R1: The input lane is sampled on rising serial-clock edges. Output data changes only after falling edges, one system clock after the edge is seen. The clock may idle low or high when select falls.
- R2: A transaction begins only on a falling select. Raising select before the opcode and the 24 address bits are complete produces no output, and the next transaction is unaffected.
- R3: An opcode other than 03h, 0Bh or 3Bh leaves both output enables low for the rest of that selection. Later transactions work normally.
- R4: The address is sent most significant bit first. Bits 23 down to ADDR_W are ignored, so only the low ADDR_W bits pick the byte.
- R5: Opcode 03h drives bit 7 of the first byte on the first falling edge after the 32nd rising edge. Bits then follow on dout, MSB first, one per clock.
- R6: Opcodes 0Bh and 3Bh take 8 more clocks of don't-care input after the address before data starts.
- R7: The byte address increments after every byte. After address 2^ADDR_W-1 it continues at 0 with no extra clocks.
- R8: Opcode 3Bh sends two bits per clock. Bit 7 goes on dout and bit 6 on aux, then bits 5/4, 3/2 and 1/0, so one byte takes 4 clocks. aux_oe is high only in this mode.
- R9: Both output enables drop within one system clock of select going high, including in the middle of a byte. They stay low while select is high.
- R10: A synchronous active-low reset returns the block to IDLE, clears the opcode and address, and drops both enables. Holding select low across reset starts nothing until select falls again.
- R11: A backdoor write stores bd_data at bd_addr on a clock edge, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sel_n_i | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial input lane |
| dout_o | output | 1 | Primary output lane data |
| dout_oe_o | output | 1 | Drive enable for dout |
| aux_o | output | 1 | Second output lane data (drives the input wire in dual mode) |
| aux_oe_o | output | 1 | Drive enable for aux |
| bd_we_i | input | 1 | Backdoor write strobe |
| bd_addr_i | input | ADDR_W | Backdoor write address |
| bd_data_i | input | 8 | Backdoor write data |

## Verification
The assertions check several properties on every cycle:
- Output data holds steady between falling edges.
- Enables fall after select is released and after reset.
- The IGNORE state never drives.
- The second lane is enabled only with the dual opcode.
- DATA is entered straight from ADDR only for 03h and through DUMMY only for the other two.

Only the bench scenarios can show that the bytes carry the right values in the right bit order. The same holds for the address bits above ADDR_W being discarded, the wrap to address 0 without a gap, an aborted header leaving later transactions intact, and a select held low across reset starting nothing.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } rd_state_t;

    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_FAST = 8'h0B;
    localparam logic [7:0] OPC_DUAL = 8'h3B;

    localparam int OPC_BITS   = 8;
    localparam int ADDR_BITS  = 24;
    localparam int DUMMY_BITS = 8;

    function automatic logic opc_known(input logic [7:0] opc);
        return (opc == OPC_READ) || (opc == OPC_FAST) || (opc == OPC_DUAL);
    endfunction

    function automatic logic opc_needs_dummy(input logic [7:0] opc);
        return (opc == OPC_FAST) || (opc == OPC_DUAL);
    endfunction
endpackage

// File: rtl/rd_edge_detect.sv
module rd_edge_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= sig_i;
    end

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise_o[g] = sig_i[g] & ~prev_q[g];
        assign fall_o[g] = ~sig_i[g] & prev_q[g];
    end
endmodule

// File: rtl/rd_byte_store.sv
module rd_byte_store #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/rd_lane_driver.sv
module rd_lane_driver (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drop_i,
    input  logic       load_i,
    input  logic       shift_i,
    input  logic       dual_i,
    input  logic [7:0] byte_i,
    output logic       so_o,
    output logic       so_oe_o,
    output logic       si_o,
    output logic       si_oe_o
);
    logic [7:0] sh_q;
    logic       oe_q;
    logic       dual_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= 8'h00;
            oe_q   <= 1'b0;
            dual_q <= 1'b0;
        end else if (drop_i) begin
            oe_q   <= 1'b0;
            dual_q <= 1'b0;
        end else if (load_i) begin
            sh_q   <= byte_i;
            oe_q   <= 1'b1;
            dual_q <= dual_i;
        end else if (shift_i) begin
            sh_q <= dual_q ? {sh_q[5:0], 2'b00} : {sh_q[6:0], 1'b0};
        end
    end

    assign so_o    = sh_q[7];
    assign si_o    = sh_q[6];
    assign so_oe_o = oe_q;
    assign si_oe_o = oe_q & dual_q;

    // R1
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i || shift_i) |=> $stable(so_o));

    // R9
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> (!so_oe_o && !si_oe_o));
endmodule

// File: rtl/flash_rd_responder.sv
module flash_rd_responder
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sel_n_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic              aux_o,
    output logic              aux_oe_o,
    input  logic              bd_we_i,
    input  logic [ADDR_W-1:0] bd_addr_i,
    input  logic [7:0]        bd_data_i
);
    localparam logic [4:0] OPC_LAST   = 5'(OPC_BITS - 1);
    localparam logic [4:0] ADDR_LAST  = 5'(ADDR_BITS - 1);
    localparam logic [4:0] DUMMY_LAST = 5'(DUMMY_BITS - 1);

    logic [1:0] rise_w, fall_w;
    logic       sck_rise, sck_fall, sel_fall, sel_rise;

    rd_state_t         state_q, state_d;
    logic [4:0]        cnt_q;
    logic [7:0]        opc_q;
    logic [7:0]        opc_next;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        beat_q;
    logic [2:0]        beat_last;
    logic              dual_w, load_w, shift_w;
    logic [7:0]        rd_byte;

    rd_edge_detect #(.W(2)) u_edges (
        .clk    (clk),
        .sig_i  ({sel_n_i, sclk_i}),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    assign sck_rise = rise_w[0];
    assign sck_fall = fall_w[0];
    assign sel_rise = rise_w[1];
    assign sel_fall = fall_w[1];

    assign opc_next = {opc_q[6:0], din_i};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (sel_n_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sel_fall) state_d = ST_OPCODE;
                end
                ST_OPCODE: begin
                    if (sck_rise && cnt_q == OPC_LAST)
                        state_d = opc_known(opc_next) ? ST_ADDR : ST_IGNORE;
                end
                ST_ADDR: begin
                    if (sck_rise && cnt_q == ADDR_LAST)
                        state_d = opc_needs_dummy(opc_q) ? ST_DUMMY : ST_DATA;
                end
                ST_DUMMY: begin
                    if (sck_rise && cnt_q == DUMMY_LAST) state_d = ST_DATA;
                end
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    assign dual_w    = (opc_q == OPC_DUAL);
    assign beat_last = dual_w ? 3'd3 : 3'd7;
    assign load_w    = (state_q == ST_DATA) && !sel_n_i && sck_fall && (beat_q == 3'd0);
    assign shift_w   = (state_q == ST_DATA) && !sel_n_i && sck_fall && (beat_q != 3'd0);

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            opc_q  <= '0;
            addr_q <= '0;
            beat_q <= '0;
        end else begin
            if (state_q != state_d) begin
                cnt_q <= '0;
            end else if (sck_rise) begin
                cnt_q <= cnt_q + 5'd1;
            end

            if (state_q == ST_OPCODE && sck_rise) begin
                opc_q <= opc_next;
            end

            if (state_q == ST_ADDR && sck_rise) begin
                addr_q <= {addr_q[ADDR_W-2:0], din_i};
            end else if (load_w) begin
                addr_q <= addr_q + 1'b1;
            end

            if (state_q != ST_DATA) begin
                beat_q <= '0;
            end else if (sck_fall) begin
                beat_q <= (beat_q == beat_last) ? 3'd0 : beat_q + 3'd1;
            end
        end
    end

    rd_byte_store #(.AW(ADDR_W)) u_store (
        .clk       (clk),
        .wr_en_i   (bd_we_i),
        .wr_addr_i (bd_addr_i),
        .wr_data_i (bd_data_i),
        .rd_addr_i (addr_q),
        .rd_data_o (rd_byte)
    );

    rd_lane_driver u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .drop_i  (sel_n_i),
        .load_i  (load_w),
        .shift_i (shift_w),
        .dual_i  (dual_w),
        .byte_i  (rd_byte),
        .so_o    (dout_o),
        .so_oe_o (dout_oe_o),
        .si_o    (aux_o),
        .si_oe_o (aux_oe_o)
    );

    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> (!dout_oe_o && !aux_oe_o));

    // R8
    aux_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_oe_o |-> (dout_oe_o && opc_q == OPC_DUAL));

    // R5
    direct_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) == ST_ADDR) |-> (opc_q == OPC_READ));

    // R6
    dummy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) == ST_DUMMY) |-> (opc_q != OPC_READ));

    // R9
    sel_rise_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise |=> (!dout_oe_o && !aux_oe_o));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!dout_oe_o && !aux_oe_o));
endmodule

// File: tb/flash_rd_responder_test.sv
module flash_rd_responder_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int HALF = 3;
    localparam int NVEC = 7;

    // {opcode[39:32], address[31:8], byte count[7:4], clock idles high[0]}
    localparam logic [39:0] VEC [NVEC] = '{
        40'h03_000010_4_0,
        40'h0B_000020_3_1,
        40'h3B_000040_4_0,
        40'h03_E000F0_3_1,
        40'h0B_0000FE_4_0,
        40'h3B_FF00FF_3_1,
        40'h03_2345C0_2_0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0;
    logic          sel_n = 1'b1;
    logic          din = 1'b0;
    logic          dout, dout_oe, aux, aux_oe;
    logic          bd_we = 1'b0;
    logic [AW-1:0] bd_addr = '0;
    logic [7:0]    bd_data = '0;

    int   checks = 0;
    int   fails = 0;
    logic done = 1'b0;
    logic hold_chk = 1'b0;
    logic [7:0] exp_mem [1 << AW];

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_rd_responder #(.ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .sel_n_i   (sel_n),
        .din_i     (din),
        .dout_o    (dout),
        .dout_oe_o (dout_oe),
        .aux_o     (aux),
        .aux_oe_o  (aux_oe),
        .bd_we_i   (bd_we),
        .bd_addr_i (bd_addr),
        .bd_data_i (bd_data)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input logic b, output logic s0, output logic s1);
        @(negedge clk);
        din = b;
        wait_n(HALF);
        s0 = dout;
        s1 = aux;
        sclk = 1'b1;
        wait_n(HALF);
        if (hold_chk)
            chk(dout == s0, "R1", "dout moved on rising edge", int'(dout), int'(s0));
        sclk = 1'b0;
        wait_n(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic x0, x1;
        for (int i = 7; i >= 0; i--) tick(b[i], x0, x1);
    endtask

    task automatic start(input logic mode3);
        @(negedge clk);
        sclk = mode3;
        wait_n(HALF);
        sel_n = 1'b0;
        wait_n(HALF);
        if (mode3) begin
            sclk = 1'b0;
            wait_n(HALF);
        end
    endtask

    task automatic stop(input logic mode3);
        @(negedge clk);
        if (mode3) sclk = 1'b1;
        wait_n(HALF);
        sel_n = 1'b1;
        wait_n(HALF);
    endtask

    task automatic read_txn(input logic [7:0] opc, input logic [23:0] addr,
                            input int n, input logic mode3, input string tag);
        logic [7:0] got;
        logic s0, s1;
        logic [AW-1:0] a;
        start(mode3);
        send_byte(opc);
        send_byte(addr[23:16]);
        send_byte(addr[15:8]);
        send_byte(addr[7:0]);
        if (opc != 8'h03) send_byte(8'hA5);
        for (int k = 0; k < n; k++) begin
            got = '0;
            if (opc == 8'h3B) begin
                for (int j = 0; j < 4; j++) begin
                    tick(1'b0, s0, s1);
                    got = {got[5:0], s0, s1};
                end
            end else begin
                for (int j = 0; j < 8; j++) begin
                    tick(1'b0, s0, s1);
                    got = {got[6:0], s0};
                end
            end
            a = addr[AW-1:0] + AW'(k);
            chk(got == exp_mem[a], tag, "read byte", int'(got), int'(exp_mem[a]));
        end
        stop(mode3);
        chk(!dout_oe && !aux_oe, "R9", "enables after deselect",
            int'({dout_oe, aux_oe}), 0);
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R5";
            1: return "R6";
            2: return "R8";
            3: return "R4";
            4: return "R7";
            5: return "R7";
            default: return "R4";
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic s0, s1;
        logic seen;
        wait_n(4);
        chk(!dout_oe && !aux_oe, "R10", "enables in reset", int'({dout_oe, aux_oe}), 0);

        // R11: load the array through the backdoor
        for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            bd_we = 1'b1;
            bd_addr = AW'(a);
            bd_data = 8'(a * 37 + 90);
            exp_mem[a] = 8'(a * 37 + 90);
        end
        @(negedge clk);
        bd_we = 1'b0;
        rst_n = 1'b1;
        wait_n(2);
        chk(!dout_oe && !aux_oe, "R10", "enables after reset", int'({dout_oe, aux_oe}), 0);

        for (int i = 0; i < NVEC; i++) begin
            read_txn(VEC[i][39:32], VEC[i][31:8], int'(VEC[i][7:4]), VEC[i][0], vec_tag(i));
        end

        // R2: abort after a partial address, then a clean read
        start(1'b0);
        send_byte(8'h03);
        send_byte(8'h00);
        chk(!dout_oe, "R2", "no drive in header", int'(dout_oe), 0);
        stop(1'b0);
        read_txn(8'h03, 24'h000033, 2, 1'b0, "R2");

        // R3: unknown opcode then long clocking
        start(1'b0);
        send_byte(8'h9F);
        seen = 1'b0;
        for (int j = 0; j < 48; j++) begin
            tick(1'b1, s0, s1);
            if (dout_oe || aux_oe) seen = 1'b1;
        end
        chk(!seen, "R3", "drive after unknown opcode", int'(seen), 0);
        stop(1'b0);
        read_txn(8'h3B, 24'h000090, 2, 1'b0, "R3");

        // R9: stop in the middle of a single-lane byte
        start(1'b0);
        send_byte(8'h03);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h30);
        for (int j = 0; j < 3; j++) tick(1'b0, s0, s1);
        chk(dout_oe, "R5", "driving in data phase", int'(dout_oe), 1);
        @(negedge clk);
        sel_n = 1'b1;
        wait_n(2);
        chk(!dout_oe && !aux_oe, "R9", "mid-byte release", int'({dout_oe, aux_oe}), 0);

        // R9 / R8: stop in the middle of a dual byte
        start(1'b0);
        send_byte(8'h3B);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h31);
        send_byte(8'h00);
        for (int j = 0; j < 2; j++) tick(1'b0, s0, s1);
        chk(aux_oe, "R8", "aux driven in dual", int'(aux_oe), 1);
        @(negedge clk);
        sel_n = 1'b1;
        wait_n(2);
        chk(!aux_oe && !dout_oe, "R9", "mid-byte dual release", int'({dout_oe, aux_oe}), 0);

        // R1: output held across rising edges
        hold_chk = 1'b1;
        read_txn(8'h03, 24'h000055, 2, 1'b0, "R1");
        hold_chk = 1'b0;

        // R10: reset during a read, select held low afterwards
        start(1'b0);
        send_byte(8'h03);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h10);
        for (int j = 0; j < 2; j++) tick(1'b0, s0, s1);
        @(negedge clk);
        rst_n = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(1);
        chk(!dout_oe && !aux_oe, "R10", "enables after mid-read reset",
            int'({dout_oe, aux_oe}), 0);
        seen = 1'b0;
        for (int j = 0; j < 40; j++) begin
            tick(1'b0, s0, s1);
            if (dout_oe) seen = 1'b1;
        end
        chk(!seen, "R10", "held select started nothing", int'(seen), 0);
        stop(1'b0);

        // R11: overwrite one byte through the backdoor
        @(negedge clk);
        bd_we = 1'b1;
        bd_addr = AW'(8'h80);
        bd_data = 8'hC3;
        exp_mem[8'h80] = 8'hC3;
        @(negedge clk);
        bd_we = 1'b0;
        read_txn(8'h0B, 24'h00007F, 3, 1'b1, "R11");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule